// File: doc/BRIEF.md
# Transceiver Management Register File

This block is the byte-addressed management memory of a pluggable optical module. A host reaches it through a plain parallel port: an 8-bit device select, an 8-bit byte offset, write data with a write strobe, and a read strobe that returns one byte on a registered read-data output. Two device selects are answered. 0xA0 opens the identification page and 0xA2 opens the diagnostic page. Any other device select reads as zero.

The identification page and the threshold area of the diagnostic page hold fixed image bytes. Their check-code bytes are produced by adders over the byte ranges they protect. The diagnostic page also exposes five live 16-bit measurement words, fed on input ports. Reading the high byte of any of these words freezes the whole word, so a following read of the low byte belongs to the same sample.

A status/control byte merges synchronized copies of the module pins with two host-writable control bits and a data-not-ready flag. The block drives the effective laser-off and full-rate outputs, each formed as the OR of a hardware pin and its soft control bit. A user scratch area in the diagnostic page can be read and written by the host.

Top module: `xcvr_mgmt_regfile`

## Requirements
- R1: A read with a device select other than 0xA0 or 0xA2 returns 0x00. Identification offsets 96 to 255 return 0x00. Diagnostic offsets 106 to 109, 111 to 127 and 248 to 255 return 0x00.
- R2: Identification offset k, for k in 0..94 other than 63, reads (k*ID_STEP + ID_SEED) mod 256. The defaults are ID_STEP=7 and ID_SEED=0x3C.
- R3: Identification offset 63 reads the low 8 bits of the sum of identification offsets 0 through 62.
- R4: Identification offset 95 reads the low 8 bits of the sum of identification offsets 64 through 94.
- R5: Diagnostic offset k, for k in 0..94, reads (k*DG_STEP + DG_SEED) mod 256, with defaults DG_STEP=13 and DG_SEED=0x51. Diagnostic offset 95 reads the low 8 bits of the sum of offsets 0 through 94.
- R6: rd_data takes the addressed byte on the clock edge that samples rd_en high. It holds its value on every edge where rd_en is low, whether or not writes occur.
- R7: The measurement words are read high byte first. Their high bytes sit at diagnostic offsets 96 (temperature), 98 (supply), 100 (bias), 102 (TX power) and 104 (RX power), and each low byte sits at the next offset. A high-byte read returns the live high byte and captures the whole word for that measurement. A low-byte read returns the captured low byte, even if the live word has changed since. Before any capture, the low byte reads 0x00.
- R8: Bit 6 of diagnostic offset 110 is a writable soft laser-off bit. laser_off equals pin_tx_disable OR that bit.
- R9: Bit 3 of diagnostic offset 110 is a writable soft full-rate bit. rate_full equals pin_rate_sel OR that bit.
- R10: After reset, rd_data is 0x00 and both soft bits are 0. The data-not-ready flag (bit 0 of offset 110) is 1, so with all pins low offset 110 reads 0x01.
- R11: Bits 7, 5, 4, 2 and 1 of offset 110 mirror pin_tx_disable, pin_rs1, pin_rate_sel, pin_tx_fault and pin_rx_los through a two-flop synchronizer. Host writes to these bits have no effect.
- R12: The data-not-ready flag clears on the first cycle meas_valid is high and stays clear until reset.
- R13: Diagnostic offsets 128 to 247 store host writes and read them back. Writes to every other location are ignored: the identification page, thresholds, check codes, measurements and unmapped offsets.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| dev_sel | input | 8 | Device select: 0xA0 identification, 0xA2 diagnostic |
| addr | input | 8 | Byte offset within the page |
| wr_data | input | 8 | Write data |
| wr_en | input | 1 | Write strobe, one byte per cycle |
| rd_en | input | 1 | Read strobe, one byte per cycle |
| rd_data | output | 8 | Registered read data |
| meas_temp | input | 16 | Live temperature word |
| meas_vcc | input | 16 | Live supply voltage word |
| meas_bias | input | 16 | Live laser bias word |
| meas_txpwr | input | 16 | Live transmit power word |
| meas_rxpwr | input | 16 | Live receive power word |
| meas_valid | input | 1 | Measurements valid, clears the not-ready flag |
| pin_tx_disable | input | 1 | Hardware laser-disable pin |
| pin_rs1 | input | 1 | Hardware secondary rate-select pin |
| pin_rate_sel | input | 1 | Hardware rate-select pin |
| pin_tx_fault | input | 1 | Transmitter fault pin |
| pin_rx_los | input | 1 | Receiver loss-of-signal pin |
| laser_off | output | 1 | Effective laser disable |
| rate_full | output | 1 | Effective full-bandwidth select |

## Verification
The assertions take for granted that the host never raises rd_en and wr_en in the same cycle. They also assume the pin inputs move only between clock edges, and that the measurement words are steady at the edge that samples a high-byte read. The bench meets these assumptions by driving every input on the falling edge and issuing reads and writes as separate one-cycle strobes. It waits at least four cycles after a pin change before reading the status byte, so the synchronizer has settled.

// File: rtl/xcvr_mgmt_pkg.sv
// Package: shared widths, page selects, offsets and status bit positions
// for the transceiver management register file.
// Assumes 8-bit offsets and byte-wide pages of 256 locations.
package xcvr_mgmt_pkg;

    localparam int AW = 8;
    localparam int BW = 8;
    localparam int WW = 16;

    typedef logic [BW-1:0] byte_t;
    typedef logic [WW-1:0] word_t;

    localparam byte_t ID_DEV = 8'hA0;
    localparam byte_t DG_DEV = 8'hA2;

    localparam int STATUS_OFS = 110;

    // Status byte bit positions (host software decodes these).
    localparam int ST_TXDIS_PIN  = 7;
    localparam int ST_SOFT_TXDIS = 6;
    localparam int ST_RS1_PIN    = 5;
    localparam int ST_RATE_PIN   = 4;
    localparam int ST_SOFT_RATE  = 3;
    localparam int ST_FAULT_PIN  = 2;
    localparam int ST_LOS_PIN    = 1;
    localparam int ST_NOT_READY  = 0;

    // Image byte generator shared by the fixed pages.
    function automatic byte_t image_byte(int k, byte_t seed, byte_t step);
        return byte_t'(k * int'(step) + int'(seed));
    endfunction

endpackage

// File: rtl/xcvr_fixed_page.sv
// Module: fixed image page with adder-computed check codes.
// Offsets 0..TOP hold generated image bytes. Offset TOP+1 holds the check
// code of the upper range. With HAS_SPLIT, offset SPLIT holds the check code
// of offsets 0..SPLIT-1, and the upper range becomes SPLIT+1..TOP.
// Offsets above TOP+1 read zero. Assumes TOP+1 < 128.
module xcvr_fixed_page
    import xcvr_mgmt_pkg::*;
#(
    parameter byte_t SEED      = 8'h3C,
    parameter byte_t STEP      = 8'd7,
    parameter int    TOP       = 94,
    parameter int    SPLIT     = 63,
    parameter bit    HAS_SPLIT = 1'b1
) (
    input  logic [AW-1:0] addr,
    output byte_t         rd_byte
);

    localparam int SPAN   = 128;
    localparam int CC_TOP = TOP + 1;

    byte_t img [SPAN];
    byte_t sum_lo;
    byte_t sum_hi;

    // Check code adders over the two protected ranges.
    always_comb begin
        sum_lo = '0;
        sum_hi = '0;
        for (int k = 0; k <= TOP; k++) begin
            if (HAS_SPLIT && k < SPLIT) begin
                sum_lo = sum_lo + image_byte(k, SEED, STEP);
            end else if (!HAS_SPLIT || k > SPLIT) begin
                sum_hi = sum_hi + image_byte(k, SEED, STEP);
            end
        end
    end

    // Page image: generated bytes, check codes, zero fill.
    for (genvar k = 0; k < SPAN; k++) begin : g_img
        if (HAS_SPLIT && k == SPLIT) begin : g_cc_lo
            assign img[k] = sum_lo;
        end else if (k == CC_TOP) begin : g_cc_hi
            assign img[k] = sum_hi;
        end else if (k <= TOP) begin : g_data
            assign img[k] = image_byte(k, SEED, STEP);
        end else begin : g_zero
            assign img[k] = '0;
        end
    end

    // Offset decode: the upper half of the page is empty.
    always_comb begin
        rd_byte = addr[AW-1] ? '0 : img[addr[AW-2:0]];
    end

endmodule

// File: rtl/xcvr_meas_snap.sv
// Module: live measurement words with a per-word capture on high-byte reads.
// Word i has its high byte at BASE+2i and its low byte at BASE+2i+1.
// Assumes rd_hit is a one-cycle read strobe already qualified by page select.
module xcvr_meas_snap
    import xcvr_mgmt_pkg::*;
#(
    parameter int NUM  = 5,
    parameter int BASE = 96
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                rd_hit,
    input  logic [AW-1:0]       addr,
    input  logic [NUM-1:0][WW-1:0] live,
    output byte_t               rd_byte,
    output logic                hit
);

    logic [NUM-1:0]         msb_sel;
    logic [NUM-1:0]         lsb_sel;
    logic [NUM-1:0][WW-1:0] hold_q;

    for (genvar i = 0; i < NUM; i++) begin : g_word
        assign msb_sel[i] = (addr == AW'(BASE + 2 * i));
        assign lsb_sel[i] = (addr == AW'(BASE + 2 * i + 1));

        // Capture the whole word when its high byte is read.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                hold_q[i] <= '0;
            end else if (rd_hit && msb_sel[i]) begin
                hold_q[i] <= live[i];
            end
        end

        assert_capture_coherent_R7: assert property (
            @(posedge clk) disable iff (!rst_n)
            (rd_hit && msb_sel[i]) |=> (hold_q[i] == $past(live[i]))
        );
    end

    // Byte select: live high byte or captured low byte.
    always_comb begin
        rd_byte = '0;
        for (int i = 0; i < NUM; i++) begin
            if (msb_sel[i]) rd_byte = live[i][WW-1:BW];
            if (lsb_sel[i]) rd_byte = hold_q[i][BW-1:0];
        end
        hit = |{msb_sel, lsb_sel};
    end

endmodule

// File: rtl/xcvr_user_mem.sv
// Module: host scratch memory covering offsets LO..HI of the diagnostic page.
// Assumes wr_hit and the offset are qualified by page select upstream.
// Contents clear on reset.
module xcvr_user_mem
    import xcvr_mgmt_pkg::*;
#(
    parameter int LO = 128,
    parameter int HI = 247
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_hit,
    input  logic [AW-1:0] addr,
    input  byte_t         wdata,
    output byte_t         rd_byte,
    output logic          hit
);

    localparam int DEPTH = HI - LO + 1;
    localparam int IW    = $clog2(DEPTH);

    byte_t          mem [DEPTH];
    logic [IW-1:0]  idx;

    // Range decode and local index.
    always_comb begin
        hit     = (addr >= AW'(LO)) && (addr <= AW'(HI));
        idx     = IW'(addr - AW'(LO));
        rd_byte = hit ? mem[idx] : '0;
    end

    // Storage update on in-range host writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int k = 0; k < DEPTH; k++) mem[k] <= '0;
        end else if (wr_hit && hit) begin
            mem[idx] <= wdata;
        end
    end

endmodule

// File: rtl/xcvr_status_ctl.sv
// Module: status/control byte. Synchronizes the five pin states and holds
// the two soft control bits and the data-not-ready flag. Drives the
// effective laser-off and full-rate outputs.
// Assumes the pins are asynchronous. The laser-off and full-rate paths use
// the raw pins so a hardware disable acts without clock delay.
module xcvr_status_ctl
    import xcvr_mgmt_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic  clk,
    input  logic  rst_n,
    input  logic  wr_hit,
    input  logic  soft_tx_wdata,
    input  logic  soft_rate_wdata,
    input  logic  meas_valid,
    input  logic  pin_tx_disable,
    input  logic  pin_rs1,
    input  logic  pin_rate_sel,
    input  logic  pin_tx_fault,
    input  logic  pin_rx_los,
    output byte_t status_byte,
    output logic  laser_off,
    output logic  rate_full
);

    localparam int NPIN = 5;

    logic [NPIN-1:0] pin_raw;
    logic [NPIN-1:0] sync_q [SYNC_STAGES];
    logic [NPIN-1:0] pin_s;
    logic            soft_tx_q;
    logic            soft_rate_q;
    logic            not_ready_q;

    assign pin_raw = {pin_tx_disable, pin_rs1, pin_rate_sel, pin_tx_fault, pin_rx_los};

    // Synchronizer chain for the pin mirrors.
    for (genvar s = 0; s < SYNC_STAGES; s++) begin : g_sync
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                sync_q[s] <= '0;
            end else if (s == 0) begin
                sync_q[s] <= pin_raw;
            end else begin
                sync_q[s] <= sync_q[(s == 0) ? 0 : s - 1];
            end
        end
    end
    assign pin_s = sync_q[SYNC_STAGES-1];

    // Soft control bits, written only through the status byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            soft_tx_q   <= 1'b0;
            soft_rate_q <= 1'b0;
        end else if (wr_hit) begin
            soft_tx_q   <= soft_tx_wdata;
            soft_rate_q <= soft_rate_wdata;
        end
    end

    // Data-not-ready flag: set by reset, cleared once by meas_valid.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            not_ready_q <= 1'b1;
        end else if (meas_valid) begin
            not_ready_q <= 1'b0;
        end
    end

    // Status byte assembly and effective control outputs.
    always_comb begin
        status_byte                = '0;
        status_byte[ST_TXDIS_PIN]  = pin_s[4];
        status_byte[ST_SOFT_TXDIS] = soft_tx_q;
        status_byte[ST_RS1_PIN]    = pin_s[3];
        status_byte[ST_RATE_PIN]   = pin_s[2];
        status_byte[ST_SOFT_RATE]  = soft_rate_q;
        status_byte[ST_FAULT_PIN]  = pin_s[1];
        status_byte[ST_LOS_PIN]    = pin_s[0];
        status_byte[ST_NOT_READY]  = not_ready_q;
        laser_off                  = pin_tx_disable | soft_tx_q;
        rate_full                  = pin_rate_sel | soft_rate_q;
    end

    assert_soft_tx_by_write_R8: assert property (
        @(posedge clk) disable iff (!rst_n)
        !$stable(soft_tx_q) |-> $past(wr_hit)
    );

    assert_laser_after_soft_set_R8: assert property (
        @(posedge clk) disable iff (!rst_n)
        (wr_hit && soft_tx_wdata) |=> laser_off
    );

    assert_rate_after_soft_set_R9: assert property (
        @(posedge clk) disable iff (!rst_n)
        (wr_hit && soft_rate_wdata) |=> rate_full
    );

    assert_ready_sticky_R12: assert property (
        @(posedge clk) disable iff (!rst_n)
        !not_ready_q |=> !not_ready_q
    );

endmodule

// File: rtl/xcvr_mgmt_regfile.sv
// Module: top of the transceiver management register file. Decodes the page
// select and offset, routes writes, and registers the read byte.
// Assumes rd_en and wr_en are never high in the same cycle.
module xcvr_mgmt_regfile
    import xcvr_mgmt_pkg::*;
#(
    parameter byte_t ID_SEED     = 8'h3C,
    parameter byte_t ID_STEP     = 8'd7,
    parameter byte_t DG_SEED     = 8'h51,
    parameter byte_t DG_STEP     = 8'd13,
    parameter int    NUM_MEAS    = 5,
    parameter int    MEAS_BASE   = 96,
    parameter int    USER_LO     = 128,
    parameter int    USER_HI     = 247,
    parameter int    SYNC_STAGES = 2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [7:0]  dev_sel,
    input  logic [7:0]  addr,
    input  logic [7:0]  wr_data,
    input  logic        wr_en,
    input  logic        rd_en,
    output logic [7:0]  rd_data,
    input  logic [15:0] meas_temp,
    input  logic [15:0] meas_vcc,
    input  logic [15:0] meas_bias,
    input  logic [15:0] meas_txpwr,
    input  logic [15:0] meas_rxpwr,
    input  logic        meas_valid,
    input  logic        pin_tx_disable,
    input  logic        pin_rs1,
    input  logic        pin_rate_sel,
    input  logic        pin_tx_fault,
    input  logic        pin_rx_los,
    output logic        laser_off,
    output logic        rate_full
);

    localparam int THR_TOP = 94;
    localparam int ID_CC0  = 63;

    logic                       id_sel;
    logic                       dg_sel;
    logic                       status_sel;
    byte_t                      id_byte;
    byte_t                      thr_byte;
    byte_t                      meas_byte;
    byte_t                      user_byte;
    byte_t                      status_byte;
    logic                       meas_hit;
    logic                       user_hit;
    logic [NUM_MEAS-1:0][WW-1:0] live;
    byte_t                      rd_next;
    byte_t                      rd_q;

    // Page and status decode.
    always_comb begin
        id_sel     = (dev_sel == ID_DEV);
        dg_sel     = (dev_sel == DG_DEV);
        status_sel = dg_sel && (addr == AW'(STATUS_OFS));
    end

    // Measurement word packing; widths above five are tied to zero.
    for (genvar i = 0; i < NUM_MEAS; i++) begin : g_live
        if (i == 0)      begin : g_t assign live[i] = meas_temp;  end
        else if (i == 1) begin : g_v assign live[i] = meas_vcc;   end
        else if (i == 2) begin : g_b assign live[i] = meas_bias;  end
        else if (i == 3) begin : g_x assign live[i] = meas_txpwr; end
        else if (i == 4) begin : g_r assign live[i] = meas_rxpwr; end
        else             begin : g_z assign live[i] = '0;         end
    end

    xcvr_fixed_page #(
        .SEED(ID_SEED), .STEP(ID_STEP), .TOP(THR_TOP),
        .SPLIT(ID_CC0), .HAS_SPLIT(1'b1)
    ) u_id_page (
        .addr   (addr),
        .rd_byte(id_byte)
    );

    xcvr_fixed_page #(
        .SEED(DG_SEED), .STEP(DG_STEP), .TOP(THR_TOP),
        .SPLIT(0), .HAS_SPLIT(1'b0)
    ) u_thr_page (
        .addr   (addr),
        .rd_byte(thr_byte)
    );

    xcvr_meas_snap #(
        .NUM(NUM_MEAS), .BASE(MEAS_BASE)
    ) u_meas (
        .clk    (clk),
        .rst_n  (rst_n),
        .rd_hit (rd_en && dg_sel),
        .addr   (addr),
        .live   (live),
        .rd_byte(meas_byte),
        .hit    (meas_hit)
    );

    xcvr_user_mem #(
        .LO(USER_LO), .HI(USER_HI)
    ) u_user (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_hit (wr_en && dg_sel),
        .addr   (addr),
        .wdata  (wr_data),
        .rd_byte(user_byte),
        .hit    (user_hit)
    );

    xcvr_status_ctl #(
        .SYNC_STAGES(SYNC_STAGES)
    ) u_status (
        .clk            (clk),
        .rst_n          (rst_n),
        .wr_hit         (wr_en && status_sel),
        .soft_tx_wdata  (wr_data[ST_SOFT_TXDIS]),
        .soft_rate_wdata(wr_data[ST_SOFT_RATE]),
        .meas_valid     (meas_valid),
        .pin_tx_disable (pin_tx_disable),
        .pin_rs1        (pin_rs1),
        .pin_rate_sel   (pin_rate_sel),
        .pin_tx_fault   (pin_tx_fault),
        .pin_rx_los     (pin_rx_los),
        .status_byte    (status_byte),
        .laser_off      (laser_off),
        .rate_full      (rate_full)
    );

    // Read mux across the two pages.
    always_comb begin
        rd_next = '0;
        if (id_sel) begin
            rd_next = id_byte;
        end else if (dg_sel) begin
            if (meas_hit)                          rd_next = meas_byte;
            else if (status_sel)                   rd_next = status_byte;
            else if (user_hit)                     rd_next = user_byte;
            else if (addr <= AW'(THR_TOP + 1))     rd_next = thr_byte;
        end
    end

    // Registered read data, updated only on a read strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_q <= '0;
        end else if (rd_en) begin
            rd_q <= rd_next;
        end
    end

    assign rd_data = rd_q;

    assert_read_hold_R6: assert property (
        @(posedge clk) disable iff (!rst_n)
        !rd_en |=> $stable(rd_data)
    );

endmodule

// File: tb/tb_xcvr_mgmt_regfile.sv
// Directed bench for the transceiver management register file.
module tb_xcvr_mgmt_regfile;

    localparam logic [7:0] ID_SEED = 8'h3C;
    localparam logic [7:0] ID_STEP = 8'd7;
    localparam logic [7:0] DG_SEED = 8'h51;
    localparam logic [7:0] DG_STEP = 8'd13;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  dev_sel = 8'h00;
    logic [7:0]  addr = 8'h00;
    logic [7:0]  wr_data = 8'h00;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [7:0]  rd_data;
    logic [15:0] meas_temp = 16'h0000;
    logic [15:0] meas_vcc = 16'h0000;
    logic [15:0] meas_bias = 16'h0000;
    logic [15:0] meas_txpwr = 16'h0000;
    logic [15:0] meas_rxpwr = 16'h0000;
    logic        meas_valid = 1'b0;
    logic        pin_tx_disable = 1'b0;
    logic        pin_rs1 = 1'b0;
    logic        pin_rate_sel = 1'b0;
    logic        pin_tx_fault = 1'b0;
    logic        pin_rx_los = 1'b0;
    logic        laser_off;
    logic        rate_full;

    int n_checks = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    xcvr_mgmt_regfile #(
        .ID_SEED(ID_SEED), .ID_STEP(ID_STEP),
        .DG_SEED(DG_SEED), .DG_STEP(DG_STEP)
    ) dut (
        .clk(clk), .rst_n(rst_n), .dev_sel(dev_sel), .addr(addr),
        .wr_data(wr_data), .wr_en(wr_en), .rd_en(rd_en), .rd_data(rd_data),
        .meas_temp(meas_temp), .meas_vcc(meas_vcc), .meas_bias(meas_bias),
        .meas_txpwr(meas_txpwr), .meas_rxpwr(meas_rxpwr), .meas_valid(meas_valid),
        .pin_tx_disable(pin_tx_disable), .pin_rs1(pin_rs1),
        .pin_rate_sel(pin_rate_sel), .pin_tx_fault(pin_tx_fault),
        .pin_rx_los(pin_rx_los), .laser_off(laser_off), .rate_full(rate_full)
    );

    function automatic logic [7:0] pat(int k, logic [7:0] seed, logic [7:0] step);
        return 8'((k * int'(step) + int'(seed)) % 256);
    endfunction

    function automatic logic [7:0] psum(int lo, int hi, logic [7:0] seed, logic [7:0] step);
        logic [7:0] s = 8'h00;
        for (int k = lo; k <= hi; k++) s = s + pat(k, seed, step);
        return s;
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic rd(input logic [7:0] dv, input logic [7:0] ofs, output logic [7:0] val);
        @(negedge clk);
        dev_sel = dv; addr = ofs; rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
        val = rd_data;
    endtask

    task automatic wr(input logic [7:0] dv, input logic [7:0] ofs, input logic [7:0] val);
        @(negedge clk);
        dev_sel = dv; addr = ofs; wr_data = val; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic expect_rd(input logic [7:0] dv, input logic [7:0] ofs,
                             input logic [7:0] exp, input string req);
        logic [7:0] v;
        rd(dv, ofs, v);
        check(v == exp, req, v, exp);
    endtask

    task automatic t_reset();
        check(rd_data == 8'h00, "R10 rd_data after reset", rd_data, 0);
        check(laser_off == 1'b0, "R10 laser_off after reset", laser_off, 0);
        check(rate_full == 1'b0, "R10 rate_full after reset", rate_full, 0);
        expect_rd(8'hA2, 8'd110, 8'h01, "R10 status after reset");
    endtask

    task automatic t_id_page();
        expect_rd(8'hA0, 8'd0,  pat(0,  ID_SEED, ID_STEP), "R2 id byte 0");
        expect_rd(8'hA0, 8'd20, pat(20, ID_SEED, ID_STEP), "R2 id byte 20");
        expect_rd(8'hA0, 8'd62, pat(62, ID_SEED, ID_STEP), "R2 id byte 62");
        expect_rd(8'hA0, 8'd64, pat(64, ID_SEED, ID_STEP), "R2 id byte 64");
        expect_rd(8'hA0, 8'd94, pat(94, ID_SEED, ID_STEP), "R2 id byte 94");
        expect_rd(8'hA0, 8'd63, psum(0, 62, ID_SEED, ID_STEP), "R3 id base check code");
        expect_rd(8'hA0, 8'd95, psum(64, 94, ID_SEED, ID_STEP), "R4 id ext check code");
    endtask

    task automatic t_diag_page();
        expect_rd(8'hA2, 8'd0,  pat(0,  DG_SEED, DG_STEP), "R5 diag byte 0");
        expect_rd(8'hA2, 8'd39, pat(39, DG_SEED, DG_STEP), "R5 diag byte 39");
        expect_rd(8'hA2, 8'd94, pat(94, DG_SEED, DG_STEP), "R5 diag byte 94");
        expect_rd(8'hA2, 8'd95, psum(0, 94, DG_SEED, DG_STEP), "R5 diag check code");
    endtask

    task automatic t_unmapped();
        expect_rd(8'h50, 8'd5,   8'h00, "R1 foreign device select");
        expect_rd(8'hA0, 8'd96,  8'h00, "R1 id byte 96");
        expect_rd(8'hA0, 8'd200, 8'h00, "R1 id byte 200");
        expect_rd(8'hA2, 8'd106, 8'h00, "R1 diag byte 106");
        expect_rd(8'hA2, 8'd120, 8'h00, "R1 diag byte 120");
        expect_rd(8'hA2, 8'd250, 8'h00, "R1 diag byte 250");
    endtask

    task automatic t_read_hold();
        logic [7:0] v;
        rd(8'hA0, 8'd20, v);
        idle(3);
        check(rd_data == v, "R6 rd_data held while idle", rd_data, v);
        wr(8'hA2, 8'd130, 8'h5A);
        check(rd_data == v, "R6 rd_data held across write", rd_data, v);
    endtask

    task automatic t_user_mem();
        wr(8'hA2, 8'd128, 8'hC3);
        wr(8'hA2, 8'd247, 8'h3E);
        expect_rd(8'hA2, 8'd128, 8'hC3, "R13 user byte 128");
        expect_rd(8'hA2, 8'd247, 8'h3E, "R13 user byte 247");
        expect_rd(8'hA2, 8'd130, 8'h5A, "R13 user byte 130");
        wr(8'hA0, 8'd10, 8'hFF);
        expect_rd(8'hA0, 8'd10, pat(10, ID_SEED, ID_STEP), "R13 id write ignored");
        wr(8'hA2, 8'd0, 8'hFF);
        expect_rd(8'hA2, 8'd0, pat(0, DG_SEED, DG_STEP), "R13 threshold write ignored");
        wr(8'hA2, 8'd95, 8'h00);
        expect_rd(8'hA2, 8'd95, psum(0, 94, DG_SEED, DG_STEP), "R13 check code write ignored");
        wr(8'hA2, 8'd248, 8'h77);
        expect_rd(8'hA2, 8'd248, 8'h00, "R13 byte 248 write ignored");
        wr(8'hA2, 8'd127, 8'h77);
        expect_rd(8'hA2, 8'd127, 8'h00, "R13 byte 127 write ignored");
        meas_bias = 16'h6677;
        wr(8'hA2, 8'd100, 8'h11);
        expect_rd(8'hA2, 8'd100, 8'h66, "R13 measurement write ignored");
    endtask

    task automatic t_snapshot();
        expect_rd(8'hA2, 8'd105, 8'h00, "R7 low byte before capture");
        meas_temp = 16'h1234;
        expect_rd(8'hA2, 8'd96, 8'h12, "R7 temp high byte");
        meas_temp = 16'hABCD;
        expect_rd(8'hA2, 8'd97, 8'h34, "R7 temp low byte from capture");
        expect_rd(8'hA2, 8'd96, 8'hAB, "R7 temp new high byte");
        expect_rd(8'hA2, 8'd97, 8'hCD, "R7 temp new low byte");
        meas_vcc = 16'h8001;
        meas_rxpwr = 16'h2468;
        expect_rd(8'hA2, 8'd98, 8'h80, "R7 vcc high byte");
        expect_rd(8'hA2, 8'd104, 8'h24, "R7 rx high byte");
        meas_vcc = 16'h0000;
        meas_rxpwr = 16'hFFFF;
        expect_rd(8'hA2, 8'd99, 8'h01, "R7 vcc low byte from capture");
        expect_rd(8'hA2, 8'd105, 8'h68, "R7 rx low byte from capture");
    endtask

    task automatic t_soft_tx();
        wr(8'hA2, 8'd110, 8'h40);
        check(laser_off == 1'b1, "R8 soft bit drives laser_off", laser_off, 1);
        expect_rd(8'hA2, 8'd110, 8'h41, "R8 soft bit readback");
        wr(8'hA2, 8'd110, 8'h00);
        check(laser_off == 1'b0, "R8 soft bit cleared", laser_off, 0);
        @(negedge clk);
        pin_tx_disable = 1'b1;
        #1;
        check(laser_off == 1'b1, "R8 pin drives laser_off", laser_off, 1);
        pin_tx_disable = 1'b0;
        #1;
        check(laser_off == 1'b0, "R8 pin released", laser_off, 0);
    endtask

    task automatic t_soft_rate();
        wr(8'hA2, 8'd110, 8'h08);
        check(rate_full == 1'b1, "R9 soft bit drives rate_full", rate_full, 1);
        check(laser_off == 1'b0, "R9 laser_off untouched", laser_off, 0);
        expect_rd(8'hA2, 8'd110, 8'h09, "R9 soft bit readback");
        wr(8'hA2, 8'd110, 8'h00);
        check(rate_full == 1'b0, "R9 soft bit cleared", rate_full, 0);
        @(negedge clk);
        pin_rate_sel = 1'b1;
        #1;
        check(rate_full == 1'b1, "R9 pin drives rate_full", rate_full, 1);
        pin_rate_sel = 1'b0;
        idle(4);
    endtask

    task automatic t_not_ready();
        @(negedge clk);
        meas_valid = 1'b1;
        @(negedge clk);
        meas_valid = 1'b0;
        expect_rd(8'hA2, 8'd110, 8'h00, "R12 not-ready cleared");
        idle(5);
        expect_rd(8'hA2, 8'd110, 8'h00, "R12 not-ready stays clear");
    endtask

    task automatic t_pin_mirror();
        @(negedge clk);
        pin_tx_disable = 1'b1; pin_rs1 = 1'b1; pin_rate_sel = 1'b1;
        pin_tx_fault = 1'b1; pin_rx_los = 1'b1;
        idle(4);
        expect_rd(8'hA2, 8'd110, 8'hB6, "R11 all pins mirrored");
        wr(8'hA2, 8'd110, 8'hB7);
        expect_rd(8'hA2, 8'd110, 8'hB6, "R11 mirror bits not writable");
        @(negedge clk);
        pin_tx_disable = 1'b0; pin_rate_sel = 1'b0; pin_rx_los = 1'b0;
        idle(4);
        expect_rd(8'hA2, 8'd110, 8'h24, "R11 partial pin pattern");
        @(negedge clk);
        pin_rs1 = 1'b0; pin_tx_fault = 1'b0;
        idle(4);
        expect_rd(8'hA2, 8'd110, 8'h00, "R11 pins low");
    endtask

    initial begin
        idle(3);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_id_page();
        t_diag_page();
        t_unmapped();
        t_read_hold();
        t_user_mem();
        t_snapshot();
        t_soft_tx();
        t_soft_rate();
        t_not_ready();
        t_pin_mirror();
        if (!finished) begin
            finished = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        for (int c = 0; c < 100000; c++) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

endmodule